// File: doc/BRIEF.md
# Debounced Level Detector with Toggle Alarm

This block watches a single-bit detector input, for example the output of a comparator that reports whether a pin sits above a threshold. It brings the input into the clock domain and exposes that value as a raw status bit. It then filters the value into a debounced flag. The filter needs the raw value to differ from the flag without a break for a programmed number of 100 ms tick strobes before the flag takes the new value. Each change of the debounced flag sets a sticky toggle status bit. A maskable alarm request follows that bit, and the host clears it with a write-one strobe.

The host sees plain control and status pins. There are no data streams and so no valid/ready handshake at the edge. The 100 ms strobe comes from an outside time base and is one clock wide. The delay code is an 8-bit count of those strobes.

Top module: `dbnc_toggle_detector`

## Requirements
- R1: While `enable_i` is 0 the debounced flag, the toggle status and the stability count stay unchanged, whatever the raw input and ticks do.
- R2: `raw_stat_o` shows `raw_i` after a two-flop synchronizer, so a change on `raw_i` appears there two clock edges later, whether or not the block is enabled.
- R3: The debounced flag takes the synchronized raw value on the clock edge that samples the N-th `tick_i` strobe counted while the two differed without a break. It does not change on any other edge.
- R4: N equals the 8-bit `delay_code_i`, which covers 1 to 255 strobes (100 ms to 25.5 s). A code of 0 behaves as 1. With code 255, 254 strobes leave the flag unchanged and the 255th strobe updates it.
- R5: Each change of the debounced flag sets `toggle_stat_o` on the same clock edge. The bit stays set until it is cleared.
- R6: `alarm_req_o` is 1 exactly when `toggle_stat_o` and `alarm_en_i` are both 1.
- R7: A one-cycle `clr_toggle_i` pulse (a host write of 1 to the toggle bit) clears `toggle_stat_o` on the next edge.
- R8: When a clear and a new flag change fall on the same edge, `toggle_stat_o` ends up set.
- R9: A tick counts nothing when the synchronized raw value already equals the flag. The count returns to zero whenever the raw value matches the flag again, so a later mismatch starts again from zero.
- R10: After reset the flag, the toggle status, the alarm request and the count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Enables debounce and alarm evaluation |
| raw_i | input | 1 | Raw asynchronous detector level |
| tick_i | input | 1 | One-clock strobe every 100 ms |
| delay_code_i | input | 8 | Debounce time in 100 ms strobes (0 acts as 1) |
| alarm_en_i | input | 1 | Alarm mask, 1 lets the toggle status raise the request |
| clr_toggle_i | input | 1 | Write-one-to-clear strobe for the toggle status |
| raw_stat_o | output | 1 | Synchronized raw detector value |
| flag_o | output | 1 | Debounced flag |
| toggle_stat_o | output | 1 | Sticky toggle status |
| alarm_req_o | output | 1 | Masked alarm request |

## Verification
The bench checks the restart rule. It breaks a mismatch after part of the count and then checks that one later strobe does not finish the count. A design that keeps the partial count would flip the flag early. It checks that strobes arriving while the raw value matches the flag add nothing. It checks the code-0 and code-255 ends of the range, where an off-by-one design would flip a strobe early or late. It also checks a clear that falls on the same edge as a toggle: a design that gives priority to the clear would lose that alarm. With the block disabled, strobes must leave the flag alone. With the mask off, a set toggle bit must not raise the request.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int unsigned CODE_W = 8;

  // Number of strobes needed for a code; a zero code acts as one.
  function automatic logic [CODE_W-1:0] eff_ticks(input logic [CODE_W-1:0] code);
    return (code == '0) ? CODE_W'(1) : code;
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbnc_timer.sv
module dbnc_timer
  import dbnc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              level_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              flag_o,
  output logic              flip_o
);
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] limit;
  logic              mismatch;
  logic              last_tick;

  assign limit     = eff_ticks(code_i);
  assign mismatch  = enable_i && (level_i != flag_o);
  assign last_tick = mismatch && tick_i && ((cnt_q + CODE_W'(1)) >= limit);
  assign flip_o    = last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (!enable_i) begin
      cnt_q  <= cnt_q;
    end else if (!mismatch) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (last_tick) begin
        cnt_q  <= '0;
        flag_o <= level_i;
      end else begin
        cnt_q  <= cnt_q + CODE_W'(1);
      end
    end
  end

  // R3: the flag only moves on an enabled tick edge
  p_flag_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag_o) |-> $past(tick_i && enable_i));

  // R1: disabled cycles freeze the flag
  p_disabled_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> $stable(flag_o));

  // R4: counter never reaches the effective limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i |-> (cnt_q < limit));
endmodule

// File: rtl/dbnc_alarm.sv
module dbnc_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_i,
  input  logic clr_i,
  input  logic mask_en_i,
  output logic status_o,
  output logic req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_o <= 1'b0;
    else if (flip_i) status_o <= 1'b1;
    else if (clr_i)  status_o <= 1'b0;
  end

  assign req_o = status_o & mask_en_i;

  // R5 and R8: a flip always leaves the status set
  p_set_on_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flip_i |=> status_o);

  // R7: a lone clear drops the status
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !flip_i) |=> !status_o);
endmodule

// File: rtl/dbnc_toggle_detector.sv
module dbnc_toggle_detector
  import dbnc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              raw_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] delay_code_i,
  input  logic              alarm_en_i,
  input  logic              clr_toggle_i,
  output logic              raw_stat_o,
  output logic              flag_o,
  output logic              toggle_stat_o,
  output logic              alarm_req_o
);
  logic raw_sync;
  logic flip;

  dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_i),
    .sync_o  (raw_sync)
  );

  assign raw_stat_o = raw_sync;

  dbnc_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .tick_i   (tick_i),
    .level_i  (raw_sync),
    .code_i   (delay_code_i),
    .flag_o   (flag_o),
    .flip_o   (flip)
  );

  dbnc_alarm u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .flip_i    (flip),
    .clr_i     (clr_toggle_i),
    .mask_en_i (alarm_en_i),
    .status_o  (toggle_stat_o),
    .req_o     (alarm_req_o)
  );

  // R5: every flag change comes with the status set
  p_flag_change_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag_o) |-> toggle_stat_o);

  // R1: disabled block keeps status unless cleared
  p_disabled_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !clr_toggle_i) |=> $stable(toggle_stat_o));
endmodule

// File: tb/dbnc_toggle_detector_bench.sv
`timescale 1ns/1ps
module dbnc_toggle_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_i = 1'b0;
  logic       raw_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] delay_code_i = 8'd1;
  logic       alarm_en_i = 1'b1;
  logic       clr_toggle_i = 1'b0;
  logic       raw_stat_o, flag_o, toggle_stat_o, alarm_req_o;
  int         errors = 0;
  int         checks = 0;

  always #5 clk = ~clk;

  dbnc_toggle_detector u_dbnc_toggle_detector (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .raw_i(raw_i),
    .tick_i(tick_i), .delay_code_i(delay_code_i), .alarm_en_i(alarm_en_i),
    .clr_toggle_i(clr_toggle_i), .raw_stat_o(raw_stat_o), .flag_o(flag_o),
    .toggle_stat_o(toggle_stat_o), .alarm_req_o(alarm_req_o)
  );

  // [15:8] code, [7] level, [6:4] ticks, [3] expected flag, [2] expected toggle
  localparam logic [15:0] VEC [9] = '{
    {8'd1, 1'b1, 3'd1, 1'b1, 1'b1, 2'b00},  // R3 fast flip
    {8'd3, 1'b0, 3'd2, 1'b1, 1'b0, 2'b00},  // R3 partial count
    {8'd3, 1'b0, 3'd1, 1'b0, 1'b1, 2'b00},  // R3 completes
    {8'd0, 1'b1, 3'd1, 1'b1, 1'b1, 2'b00},  // R4 code 0 acts as 1
    {8'd2, 1'b1, 3'd3, 1'b1, 1'b0, 2'b00},  // R9 equal value counts nothing
    {8'd2, 1'b0, 3'd1, 1'b1, 1'b0, 2'b00},  // R9 partial
    {8'd2, 1'b1, 3'd0, 1'b1, 1'b0, 2'b00},  // R9 match clears count
    {8'd2, 1'b0, 3'd1, 1'b1, 1'b0, 2'b00},  // R9 restart from zero
    {8'd2, 1'b0, 3'd1, 1'b0, 1'b1, 2'b00}   // R5 toggle after restart
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic clear_pulse();
    @(negedge clk) clr_toggle_i = 1'b1;
    @(negedge clk) clr_toggle_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 flag", flag_o, 1'b0);
    check("R10 toggle", toggle_stat_o, 1'b0);
    check("R10 req", alarm_req_o, 1'b0);
    rst_n = 1'b1;

    // R2: raw status visible while disabled, two edges later
    @(negedge clk) raw_i = 1'b1;
    @(negedge clk) check("R2 one edge", raw_stat_o, 1'b0);
    @(negedge clk) check("R2 two edges", raw_stat_o, 1'b1);
    // R1: disabled block ignores ticks
    ticks(3);
    check("R1 flag held", flag_o, 1'b0);
    check("R1 toggle held", toggle_stat_o, 1'b0);
    raw_i = 1'b0;
    settle();
    enable_i = 1'b1;

    for (int v = 0; v < 9; v++) begin
      delay_code_i = VEC[v][15:8];
      raw_i = VEC[v][7];
      settle();
      ticks(int'(VEC[v][6:4]));
      check($sformatf("R3 vec%0d flag", v), flag_o, VEC[v][3]);
      check($sformatf("R5 vec%0d toggle", v), toggle_stat_o, VEC[v][2]);
      check($sformatf("R6 vec%0d req", v), alarm_req_o, VEC[v][2]);
      clear_pulse();
      check($sformatf("R7 vec%0d cleared", v), toggle_stat_o, 1'b0);
    end

    // R4: code 255 boundary; flag is 0 here
    delay_code_i = 8'd255;
    raw_i = 1'b1;
    settle();
    ticks(254);
    check("R4 254 ticks", flag_o, 1'b0);
    ticks(1);
    check("R4 255th tick", flag_o, 1'b1);

    // R6: mask off keeps request low while status set
    check("R5 status set", toggle_stat_o, 1'b1);
    alarm_en_i = 1'b0;
    @(negedge clk) check("R6 masked", alarm_req_o, 1'b0);
    alarm_en_i = 1'b1;
    @(negedge clk) check("R6 unmasked", alarm_req_o, 1'b1);
    clear_pulse();

    // R8: clear on the same edge as a flip leaves status set
    delay_code_i = 8'd1;
    raw_i = 1'b0;
    settle();
    @(negedge clk) begin tick_i = 1'b1; clr_toggle_i = 1'b1; end
    @(negedge clk) begin tick_i = 1'b0; clr_toggle_i = 1'b0; end
    check("R8 flag flipped", flag_o, 1'b0);
    check("R8 set wins", toggle_stat_o, 1'b1);

    // R1: disabling mid-count freezes count and flag
    clear_pulse();
    delay_code_i = 8'd2;
    raw_i = 1'b1;
    settle();
    ticks(1);
    enable_i = 1'b0;
    ticks(4);
    check("R1 frozen flag", flag_o, 1'b0);
    enable_i = 1'b1;
    ticks(1);
    check("R1 count kept", flag_o, 1'b1);

    // R10: reset clears state again
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) begin
      check("R10 flag after reset", flag_o, 1'b0);
      check("R10 toggle after reset", toggle_stat_o, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule